// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. It sits next to a free-running count and works in one of two modes. In compare mode, software writes a shadow value. The shadow value moves into a working threshold either at once or on the timer's update pulse, as a transfer-enable input selects. The working threshold is compared with the count to produce a pulse-width-modulated output. In capture mode, a rising edge on the capture pin freezes the current count into the same storage that software reads.

Status flags report compare hits, captures and lost captures (a capture that arrives before software clears the previous one). Each flag stays set until its clear bit is pulsed. A set and a clear that arrive in the same cycle leave the flag set. The asynchronous reset is released in step with the clock.

Top module: `cc_channel`

## Requirements
- R1: After reset, `rd_data` is 0, `oc_out` is 0 and all three flags are 0. The working threshold is 0.
- R2: In compare mode (`mode_in`=0), a write (`wr_en`=1) updates `rd_data` to `wr_data` one clock later.
- R3: With `preload_en`=0 in compare mode, a write also loads the working threshold on the same clock edge.
- R4: With `preload_en`=1 in compare mode, the working threshold keeps its value until a clock with `update_evt`=1. On that clock it takes the shadow value. It never changes in capture mode.
- R5: `oc_out` is registered. After each clock it is 1 when the mode is compare and the count is strictly below the working threshold. Otherwise it is 0, and it is always 0 in capture mode.
- R6: In compare mode, a clock where the count equals the working threshold sets `flags_out[0]` (compare hit). The flag stays set until a clock with `flag_clr[0]`=1. It is never set in capture mode.
- R7: In capture mode (`mode_in`=1), a clock where `cap_in` is 1 and was 0 on the previous clock stores `count` into the register, and `rd_data` shows it. A level held high captures only once.
- R8: In capture mode, software writes have no effect on `rd_data`.
- R9: A capture sets `flags_out[1]`. A capture while `flags_out[1]` is already 1 also sets `flags_out[2]` (lost capture). `flag_clr[1]` and `flag_clr[2]` clear them, and a set in the same clock wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_in | input | 1 | 0 = compare, 1 = capture |
| preload_en | input | 1 | 1 = shadow value moves to threshold only on update |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 16 | Software write value |
| rd_data | output | 16 | Shadow or captured value |
| count | input | 16 | Timer count |
| update_evt | input | 1 | Timer update pulse |
| cap_in | input | 1 | Capture pin, rising edge active |
| flag_clr | input | 3 | Clear strobes {lost, capture, compare} |
| oc_out | output | 1 | Compare output |
| flags_out | output | 3 | Flags {lost, capture, compare} |

## Verification
The working threshold cannot be read, so a wrong threshold shows up only through `oc_out` and the compare flag. The bench therefore sweeps the count to one below, and then exactly onto, the threshold it expects. A threshold error shows on `oc_out` one clock after the count reaches the wrong boundary, and on the compare flag in that same clock. Errors in the shared register or the capture edge detector appear on `rd_data` the clock after the write or edge. A flag priority error appears the clock after a capture.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned CC_NFLAGS = 3;

  typedef enum logic {
    CC_MODE_OUT = 1'b0,
    CC_MODE_IN  = 1'b1
  } cc_mode_e;

  typedef struct packed {
    logic lost;
    logic cap;
    logic hit;
  } cc_flags_t;
endpackage

// File: rtl/cc_rst_sync.sv
module cc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/cc_regs.sv
module cc_regs
  import cc_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cc_mode_e         mode,
  input  logic             preload_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             update_evt,
  input  logic             cap_in,
  input  logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] shadow_q,
  output logic [WIDTH-1:0] thresh_q,
  output logic             cap_evt
);
  logic             pin_q;
  logic [WIDTH-1:0] shadow_d, thresh_d;
  logic             shadow_en, thresh_en;

  assign cap_evt = (mode == CC_MODE_IN) && cap_in && !pin_q;

  always_comb begin
    shadow_en = 1'b0;
    shadow_d  = shadow_q;
    if (mode == CC_MODE_IN) begin
      if (cap_evt) begin
        shadow_en = 1'b1;
        shadow_d  = count;
      end
    end else if (wr_en) begin
      shadow_en = 1'b1;
      shadow_d  = wr_data;
    end
  end

  always_comb begin
    thresh_en = 1'b0;
    thresh_d  = thresh_q;
    if (mode == CC_MODE_OUT) begin
      if (!preload_en) begin
        if (wr_en) begin
          thresh_en = 1'b1;
          thresh_d  = wr_data;
        end
      end else if (update_evt) begin
        thresh_en = 1'b1;
        thresh_d  = shadow_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q    <= 1'b0;
      shadow_q <= '0;
      thresh_q <= '0;
    end else begin
      pin_q <= cap_in;
      if (shadow_en) shadow_q <= shadow_d;
      if (thresh_en) thresh_q <= thresh_d;
    end
  end

  assert_input_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CC_MODE_IN && !cap_evt) |=> $stable(shadow_q));

  assert_capture_loads_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (shadow_q == $past(count)));

  assert_thresh_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CC_MODE_IN || (preload_en && !update_evt)) |=> $stable(thresh_q));
endmodule

// File: rtl/cc_compare.sv
module cc_compare
  import cc_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cc_mode_e         mode,
  input  logic [WIDTH-1:0] count,
  input  logic [WIDTH-1:0] thresh,
  output logic             oc_q,
  output logic             hit
);
  logic oc_d;

  always_comb begin
    oc_d = (mode == CC_MODE_OUT) && (count < thresh);
    hit  = (mode == CC_MODE_OUT) && (count == thresh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_d;
  end

  assert_oc_low_in_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CC_MODE_IN) |=> !oc_q);
endmodule

// File: rtl/cc_flags.sv
module cc_flags
  import cc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_set,
  input  logic      cap_set,
  input  cc_flags_t clr,
  output cc_flags_t flags_q
);
  cc_flags_t flags_d;

  always_comb begin
    flags_d.hit  = hit_set | (flags_q.hit  & ~clr.hit);
    flags_d.cap  = cap_set | (flags_q.cap  & ~clr.cap);
    flags_d.lost = (cap_set & flags_q.cap) | (flags_q.lost & ~clr.lost);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assert_lost_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.lost) |-> $past(flags_q.cap));

  assert_capture_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_set |=> flags_q.cap);
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_in,
  input  logic             preload_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] count,
  input  logic             update_evt,
  input  logic             cap_in,
  input  logic [2:0]       flag_clr,
  output logic             oc_out,
  output logic [2:0]       flags_out
);
  logic             rst_n_int;
  cc_mode_e         mode;
  logic [WIDTH-1:0] shadow, thresh;
  logic             cap_evt, hit;
  cc_flags_t        flags, clr;

  assign mode = cc_mode_e'(mode_in);
  assign clr  = cc_flags_t'(flag_clr);

  cc_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  cc_regs #(.WIDTH(WIDTH)) regs_i (
    .clk(clk), .rst_n(rst_n_int), .mode(mode), .preload_en(preload_en),
    .wr_en(wr_en), .wr_data(wr_data), .update_evt(update_evt),
    .cap_in(cap_in), .count(count), .shadow_q(shadow), .thresh_q(thresh),
    .cap_evt(cap_evt)
  );

  cc_compare #(.WIDTH(WIDTH)) cmp_i (
    .clk(clk), .rst_n(rst_n_int), .mode(mode), .count(count),
    .thresh(thresh), .oc_q(oc_out), .hit(hit)
  );

  cc_flags flg_i (
    .clk(clk), .rst_n(rst_n_int), .hit_set(hit), .cap_set(cap_evt),
    .clr(clr), .flags_q(flags)
  );

  assign rd_data   = shadow;
  assign flags_out = flags;

  assert_hit_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode_in == 1'b0 && count == thresh) |=> flags_out[0]);

  assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mode_in == 1'b0 && !preload_en && wr_en) |=> (thresh == $past(wr_data)));
endmodule

// File: tb/cc_channel_tb.sv
module cc_channel_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n, mode_in, preload_en, wr_en, update_evt, cap_in;
  logic [W-1:0] wr_data, count, rd_data;
  logic [2:0]   flag_clr, flags_out;
  logic         oc_out;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;   // 0 = rd_data, 1 = oc_out, 2 = flags_out
    logic [15:0] exp;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  cc_channel #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .preload_en(preload_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .count(count),
    .update_evt(update_evt), .cap_in(cap_in), .flag_clr(flag_clr),
    .oc_out(oc_out), .flags_out(flags_out)
  );

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = sb_q.pop_front();
      case (e.kind)
        0:       act = rd_data;
        1:       act = {15'd0, oc_out};
        default: act = {13'd0, flags_out};
      endcase
      total++;
      if (act !== e.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int kind, logic [15:0] exp, string req);
    exp_t e;
    e.kind = kind; e.exp = exp; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic sw_write(logic [15:0] v);
    wr_data = v; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic clear_flags(logic [2:0] m);
    flag_clr = m;
    cyc();
    flag_clr = 3'b000;
  endtask

  // sweeps count around threshold v (v > 0); checks output and hit flag
  task automatic probe_thresh(logic [15:0] v, string req);
    count = v - 16'd1;
    cyc();
    push(1, 16'd1, req);            // R5: below threshold -> high
    push(2, 16'd0, "R6 no hit below");
    count = v;
    cyc();
    push(1, 16'd0, req);            // R5: at threshold -> low
    push(2, 16'd1, "R6 hit set");
    count = 16'hFFFF;
    cyc();
    push(1, 16'd0, "R5 above threshold");
    push(2, 16'd1, "R6 hit sticky");
    clear_flags(3'b001);
    push(2, 16'd0, "R6 hit cleared");
  endtask

  initial begin
    rst_n = 1'b0; mode_in = 1'b0; preload_en = 1'b0; wr_en = 1'b0;
    update_evt = 1'b0; cap_in = 1'b0; wr_data = '0; count = 16'hFFFF;
    flag_clr = 3'b000;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    push(0, 16'h0000, "R1 rd_data");
    push(1, 16'd0,    "R1 oc_out");
    push(2, 16'd0,    "R1 flags");
    cyc();

    // R2, R3: direct load
    sw_write(16'h0100);
    push(0, 16'h0100, "R2 readback");
    probe_thresh(16'h0100, "R3 direct threshold");

    // R4: shadowed load
    preload_en = 1'b1;
    sw_write(16'h0300);
    push(0, 16'h0300, "R2 readback shadowed");
    probe_thresh(16'h0100, "R4 threshold held before update");
    update_evt = 1'b1;
    cyc();
    update_evt = 1'b0;
    probe_thresh(16'h0300, "R4 threshold after update");

    // R5, R6 in capture mode
    mode_in = 1'b1;
    count = 16'h0000;
    cyc();
    push(1, 16'd0, "R5 low in capture mode");
    count = 16'h0300;
    cyc();
    push(2, 16'd0, "R6 no hit in capture mode");

    // R8: write ignored
    sw_write(16'h1234);
    push(0, 16'h0300, "R8 write ignored");

    // R7, R9: capture
    count = 16'h0ABC; cap_in = 1'b1;
    cyc();
    push(0, 16'h0ABC, "R7 capture value");
    push(2, 16'b010,  "R9 capture flag");
    count = 16'h0DEF;
    cyc();
    push(0, 16'h0ABC, "R7 held level no recapture");
    cap_in = 1'b0;
    cyc();
    count = 16'h0111; cap_in = 1'b1;
    cyc();
    push(0, 16'h0111, "R7 second capture");
    push(2, 16'b110,  "R9 lost capture flag");
    cap_in = 1'b0;
    clear_flags(3'b110);
    push(2, 16'b000, "R9 flags cleared");
    // set beats clear
    count = 16'h0222; cap_in = 1'b1; flag_clr = 3'b010;
    cyc();
    flag_clr = 3'b000; cap_in = 1'b0;
    push(2, 16'b010, "R9 set wins over clear");
    push(0, 16'h0222, "R7 third capture");

    repeat (3) cyc();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule